// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block drives the enable lines of six regulator groups on a board. It brings the groups up one rank at a time in a power-up ranking and takes them down in a separate power-down ranking. Before each rank switches, the controller waits that rank's own delay, counted in clock ticks. After a rank is switched on, the controller waits for the power-good flags of that rank before it moves on. If those flags do not arrive within a timeout, it latches a fault and shuts every group down. Rail health arrives as already-digitised per-group flags: power good, over-voltage and under-voltage.

The target state of the groups comes from one of three sources, chosen by a mode input. In automatic mode every group comes up after reset and stays up. In control mode a single on/off input brings the groups up when asserted and takes them down when released. In pin-selected mode three select pins pick one of eight build-time on/off patterns, and only the groups whose state differs from the current one are sequenced.

If the target changes in the middle of a sequence, the running step is dropped. Sequencing then resumes toward the new target from whatever groups are on at that moment. A release of the control input also fires a reset pulse whose length is a parameter. The polarities of the control input, the select pins and the pulse output are parameters.

Top module: `pwrseq_top`

## Requirements
- R1: After reset all enables are low, no fault flag is set, `toFault` is low and `rstPulse` sits at its inactive level (high with the default active-low polarity).
- R2: In control mode (`modeSel`=2'b01), asserting `ctrlIn` enables the groups in ascending power-up rank (default ranks per group index 0..5: 0,1,5,2,3,4). The first rank's enable rises exactly 3 + its on-delay clock edges after the input changes (7 edges with the default on-delay of 4 for group index 0).
- R3: Releasing `ctrlIn` disables the enabled groups in ascending power-down rank (default 0,1,2,0,2,2). Groups that share a rank, such as indices 0 and 3, drop on the same clock edge.
- R4: In automatic mode (`modeSel`=2'b00) all groups are enabled in power-up order, and toggling `ctrlIn` never turns any group off.
- R5: `allGood` is high exactly when every bit of `pgIn` is high, including bits of groups that are not yet enabled.
- R6: A high bit on `ovIn` or `uvIn` sets the matching flag, which stays set after the input clears and after `ctrlIn` is released. The flag clears one edge after `ctrlIn` is asserted again.
- R7: In pin-selected mode (`modeSel`=2'b10), `pinSel` indexes an 8-entry pattern table (default 00,3F,03,0F,30,15,2A,3C hex, bit g = group g). Groups being switched off go first, in power-down rank. Groups being switched on follow, in power-up rank. Groups whose state does not change are never toggled.
- R8: If an enabled rank lacks power good for TIMEOUT cycles (default 20), `toFault` sets and every group is sequenced off. The fault clears, and power-up resumes, when `ctrlIn` is asserted again.
- R9: A target change during a sequence abandons the running step: no group moves away from the new target, and the groups settle at the new target.
- R10: Releasing `ctrlIn` drives `rstPulse` active for exactly PULSE_LEN cycles (default 40), starting one edge after the release.
- R11: On no clock edge do some enables rise while others fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Target source: 00 automatic, 01 control input, 10 select pins, 11 as 01 |
| ctrlIn | input | 1 | On/off control input (polarity set by parameter) |
| pinSel | input | 3 | Pattern select pins (polarity set by parameter) |
| pgIn | input | 6 | Per-group power-good flags |
| ovIn | input | 6 | Per-group over-voltage flags |
| uvIn | input | 6 | Per-group under-voltage flags |
| enOut | output | 6 | Regulator group enables |
| allGood | output | 1 | High when every group reports power good |
| ovFlag | output | 6 | Latched over-voltage status |
| uvFlag | output | 6 | Latched under-voltage status |
| toFault | output | 1 | Latched power-good timeout fault |
| rstPulse | output | 1 | Reset pulse fired on control release |

## Verification
Some properties are checked on every clock cycle: rises and falls of the enables never share an edge, and fault flags latch and then clear only after a control rise. Automatic mode never drops an enable while no timeout is pending. A set timeout fault blocks any further enable from rising. Rank ordering, tied ranks dropping together, the exact first-rank latency, the reset-pulse length, pattern selection, timeout shutdown with recovery, and abandonment of a sequence mid-flight depend on the chosen targets and timing. Those are shown by the bench's scenarios, against a regulator model that answers each enable with power good.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO = 2'b00,
    MODE_CTRL = 2'b01,
    MODE_PIN  = 2'b10
  } seqMode_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic abandon;
    logic loadBatch;
    logic cntInc;
    logic applyBatch;
    logic toSet;
  } seqStrobe_t;

  // status from the datapath back to the control FSM
  typedef struct packed {
    logic tgtChg;
    logic anyPend;
    logic dlyDone;
    logic pgOk;
    logic toExpired;
    logic batchUp;
  } seqStatus_t;

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t status,
  output seqStrobe_t strobe
);

  typedef enum logic [1:0] {S_IDLE, S_DLY, S_PG} seqState_e;

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (status.tgtChg) begin
      strobe.abandon = 1'b1;
      nextState      = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (status.anyPend) begin
          strobe.loadBatch = 1'b1;
          nextState        = S_DLY;
        end
        S_DLY: if (status.dlyDone) begin
          strobe.applyBatch = 1'b1;
          nextState         = status.batchUp ? S_PG : S_IDLE;
        end else begin
          strobe.cntInc = 1'b1;
        end
        S_PG: if (status.pgOk) begin
          nextState = S_IDLE;
        end else if (status.toExpired) begin
          strobe.toSet = 1'b1;
          nextState    = S_IDLE;
        end else begin
          strobe.cntInc = 1'b1;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int NGRP            = 6,
  parameter int NPIN            = 3,
  parameter int ON_RANK  [NGRP] = '{0, 1, 5, 2, 3, 4},
  parameter int OFF_RANK [NGRP] = '{0, 1, 2, 0, 2, 2},
  parameter int ON_DLY   [NGRP] = '{4, 3, 2, 2, 3, 5},
  parameter int OFF_DLY  [NGRP] = '{2, 3, 2, 2, 1, 4},
  parameter logic [NGRP-1:0] PIN_PAT [2**NPIN] =
    '{6'h00, 6'h3F, 6'h03, 6'h0F, 6'h30, 6'h15, 6'h2A, 6'h3C},
  parameter int TIMEOUT         = 20,
  parameter int MAX_DLY         = 15,
  parameter int PULSE_LEN       = 40,
  parameter bit CTRL_ACT_HIGH   = 1'b1,
  parameter bit PIN_ACT_HIGH    = 1'b1,
  parameter bit PULSE_ACT_HIGH  = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      modeSel,
  input  logic            ctrlIn,
  input  logic [NPIN-1:0] pinSel,
  input  logic [NGRP-1:0] pgIn,
  input  logic [NGRP-1:0] ovIn,
  input  logic [NGRP-1:0] uvIn,
  input  seqStrobe_t      strobe,
  output seqStatus_t      status,
  output logic [NGRP-1:0] enOut,
  output logic            allGood,
  output logic [NGRP-1:0] ovFlag,
  output logic [NGRP-1:0] uvFlag,
  output logic            toFault,
  output logic            rstPulse
);

  localparam int CNT_MAX = (TIMEOUT > MAX_DLY) ? TIMEOUT : MAX_DLY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PUL_W   = $clog2(PULSE_LEN + 1);

  logic            ctrlEff, ctrlQ, ctrlRise, ctrlFall;
  logic [NPIN-1:0] pinIdx;
  logic [NGRP-1:0] tgt, tgtQ, en, pendOff, pendOn, pool;
  logic [NGRP-1:0] batch, nextBatch;
  logic            batchUp, pickDown;
  logic [CNT_W-1:0] cnt, batchDly, nextDly;
  logic [PUL_W-1:0] pulseCnt;

  assign ctrlEff  = CTRL_ACT_HIGH ? ctrlIn : ~ctrlIn;
  assign pinIdx   = PIN_ACT_HIGH ? pinSel : ~pinSel;
  assign ctrlRise = ctrlEff & ~ctrlQ;
  assign ctrlFall = ~ctrlEff & ctrlQ;

  // target state of every group
  always_comb begin
    if (toFault) begin
      tgt = '0;
    end else begin
      unique case (modeSel)
        MODE_AUTO: tgt = '1;
        MODE_PIN:  tgt = PIN_PAT[pinIdx];
        default:   tgt = {NGRP{ctrlEff}};
      endcase
    end
  end

  assign pendOff  = en & ~tgt;
  assign pendOn   = tgt & ~en;
  assign pickDown = |pendOff;
  assign pool     = pickDown ? pendOff : pendOn;

  // lowest-ranked pending groups form the next batch; its delay is the largest member delay
  always_comb begin
    int minRank;
    minRank   = NGRP + 1;
    nextBatch = '0;
    nextDly   = '0;
    for (int g = 0; g < NGRP; g++) begin
      int rk;
      rk = pickDown ? OFF_RANK[g] : ON_RANK[g];
      if (pool[g] && rk < minRank) minRank = rk;
    end
    for (int g = 0; g < NGRP; g++) begin
      int rk;
      int dl;
      rk = pickDown ? OFF_RANK[g] : ON_RANK[g];
      dl = pickDown ? OFF_DLY[g] : ON_DLY[g];
      if (pool[g] && rk == minRank) begin
        nextBatch[g] = 1'b1;
        if (CNT_W'(dl) > nextDly) nextDly = CNT_W'(dl);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ     <= '0;
      en       <= '0;
      batch    <= '0;
      batchUp  <= 1'b0;
      batchDly <= '0;
      cnt      <= '0;
      ctrlQ    <= 1'b0;
      toFault  <= 1'b0;
      pulseCnt <= '0;
    end else begin
      tgtQ  <= tgt;
      ctrlQ <= ctrlEff;
      if (strobe.loadBatch) begin
        batch    <= nextBatch;
        batchUp  <= ~pickDown;
        batchDly <= nextDly;
      end
      if (strobe.applyBatch) en <= batchUp ? (en | batch) : (en & ~batch);
      if (strobe.abandon || strobe.loadBatch || strobe.applyBatch) cnt <= '0;
      else if (strobe.cntInc && cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      toFault <= strobe.toSet | (toFault & ~ctrlRise);
      if (ctrlFall)            pulseCnt <= PUL_W'(PULSE_LEN);
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // per-group fault latches
  for (genvar g = 0; g < NGRP; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ovFlag[g] <= 1'b0;
        uvFlag[g] <= 1'b0;
      end else begin
        ovFlag[g] <= ovIn[g] | (ovFlag[g] & ~ctrlRise);
        uvFlag[g] <= uvIn[g] | (uvFlag[g] & ~ctrlRise);
      end
    end
  end

  assign enOut    = en;
  assign allGood  = &pgIn;
  assign rstPulse = (pulseCnt != '0) ~^ PULSE_ACT_HIGH;

  assign status.tgtChg    = (tgt != tgtQ);
  assign status.anyPend   = |(pendOff | pendOn);
  assign status.dlyDone   = (cnt == batchDly);
  assign status.pgOk      = ((pgIn & batch) == batch);
  assign status.toExpired = (cnt >= CNT_W'(TIMEOUT));
  assign status.batchUp   = batchUp;

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int NGRP            = 6,
  parameter int NPIN            = 3,
  parameter int ON_RANK  [NGRP] = '{0, 1, 5, 2, 3, 4},
  parameter int OFF_RANK [NGRP] = '{0, 1, 2, 0, 2, 2},
  parameter int ON_DLY   [NGRP] = '{4, 3, 2, 2, 3, 5},
  parameter int OFF_DLY  [NGRP] = '{2, 3, 2, 2, 1, 4},
  parameter logic [NGRP-1:0] PIN_PAT [2**NPIN] =
    '{6'h00, 6'h3F, 6'h03, 6'h0F, 6'h30, 6'h15, 6'h2A, 6'h3C},
  parameter int TIMEOUT         = 20,
  parameter int MAX_DLY         = 15,
  parameter int PULSE_LEN       = 40,
  parameter bit CTRL_ACT_HIGH   = 1'b1,
  parameter bit PIN_ACT_HIGH    = 1'b1,
  parameter bit PULSE_ACT_HIGH  = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      modeSel,
  input  logic            ctrlIn,
  input  logic [NPIN-1:0] pinSel,
  input  logic [NGRP-1:0] pgIn,
  input  logic [NGRP-1:0] ovIn,
  input  logic [NGRP-1:0] uvIn,
  output logic [NGRP-1:0] enOut,
  output logic            allGood,
  output logic [NGRP-1:0] ovFlag,
  output logic [NGRP-1:0] uvFlag,
  output logic            toFault,
  output logic            rstPulse
);

  seqStrobe_t strobe;
  seqStatus_t status;

  pwrseq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

  pwrseq_dp #(
    .NGRP(NGRP), .NPIN(NPIN), .ON_RANK(ON_RANK), .OFF_RANK(OFF_RANK),
    .ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY), .PIN_PAT(PIN_PAT),
    .TIMEOUT(TIMEOUT), .MAX_DLY(MAX_DLY), .PULSE_LEN(PULSE_LEN),
    .CTRL_ACT_HIGH(CTRL_ACT_HIGH), .PIN_ACT_HIGH(PIN_ACT_HIGH),
    .PULSE_ACT_HIGH(PULSE_ACT_HIGH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .ctrlIn   (ctrlIn),
    .pinSel   (pinSel),
    .pgIn     (pgIn),
    .ovIn     (ovIn),
    .uvIn     (uvIn),
    .strobe   (strobe),
    .status   (status),
    .enOut    (enOut),
    .allGood  (allGood),
    .ovFlag   (ovFlag),
    .uvFlag   (uvFlag),
    .toFault  (toFault),
    .rstPulse (rstPulse)
  );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int NGRP          = 6,
  parameter bit CTRL_ACT_HIGH = 1'b1
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      modeSel,
  input logic            ctrlIn,
  input logic [NGRP-1:0] ovIn,
  input logic [NGRP-1:0] uvIn,
  input logic [NGRP-1:0] enOut,
  input logic [NGRP-1:0] ovFlag,
  input logic [NGRP-1:0] uvFlag,
  input logic            toFault
);

  logic ctrlEff;
  assign ctrlEff = CTRL_ACT_HIGH ? ctrlIn : ~ctrlIn;

  // R11: never raise and lower enables on one edge
  p_no_mixed_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(((enOut & ~$past(enOut)) != '0) && ((~enOut & $past(enOut)) != '0)));

  // R6: a reported fault is latched
  p_ov_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((ovFlag & $past(ovIn)) == $past(ovIn)));

  p_uv_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((uvFlag & $past(uvIn)) == $past(uvIn)));

  // R6: a flag only drops after a control rise
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (((~ovFlag & $past(ovFlag)) | (~uvFlag & $past(uvFlag))) != '0)
      |-> ($past(ctrlEff) && !$past(ctrlEff, 2)));

  // R4: automatic mode never drops an enable without a timeout fault
  p_auto_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && $past(modeSel) == 2'b00 && !toFault && !$past(toFault))
      |-> ((enOut & $past(enOut)) == $past(enOut)));

  // R8: a standing timeout fault lets no enable rise
  p_fault_no_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(toFault) && toFault) |-> ((enOut & ~$past(enOut)) == '0));

endmodule

bind pwrseq_top pwrseq_chk #(.NGRP(NGRP), .CTRL_ACT_HIGH(CTRL_ACT_HIGH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .modeSel (modeSel),
  .ctrlIn  (ctrlIn),
  .ovIn    (ovIn),
  .uvIn    (uvIn),
  .enOut   (enOut),
  .ovFlag  (ovFlag),
  .uvFlag  (uvFlag),
  .toFault (toFault)
);

// File: tb/test_pwrseq_top.sv
module test_pwrseq_top;

  localparam int CLK_P  = 10;
  localparam int NG     = 6;
  localparam int PLEN   = 40;
  localparam int G0_DLY = 4;
  localparam int ON_R  [NG] = '{0, 1, 5, 2, 3, 4};
  localparam int OFF_R [NG] = '{0, 1, 2, 0, 2, 2};
  localparam logic [NG-1:0] PAT [8] =
    '{6'h00, 6'h3F, 6'h03, 6'h0F, 6'h30, 6'h15, 6'h2A, 6'h3C};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'b01;
  logic          ctrlIn = 1'b0;
  logic [2:0]    pinSel = 3'd0;
  logic [NG-1:0] pgIn, pgReg, pgRand, pgBlock;
  logic          pgManual;
  logic [NG-1:0] ovIn = '0, uvIn = '0;
  logic [NG-1:0] enOut, ovFlag, uvFlag;
  logic          allGood, toFault, rstPulse;

  int chkCnt = 0, errCnt = 0, ordErr = 0;
  logic [NG-1:0] expTgt, prevEn;
  logic monOn, tieSeen, tieHit;

  always #(CLK_P/2) clk = ~clk;

  assign pgIn = pgManual ? pgRand : pgReg;

  pwrseq_top i_pwrseq_top (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .ctrlIn(ctrlIn), .pinSel(pinSel),
    .pgIn(pgIn), .ovIn(ovIn), .uvIn(uvIn), .enOut(enOut), .allGood(allGood),
    .ovFlag(ovFlag), .uvFlag(uvFlag), .toFault(toFault), .rstPulse(rstPulse)
  );

  // regulator model and order monitor
  initial begin
    pgReg = '0; prevEn = '0; tieSeen = 1'b0; tieHit = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        logic [NG-1:0] rise, fall;
        rise = enOut & ~prevEn;
        fall = ~enOut & prevEn;
        if (monOn) begin
          if (rise != '0 && fall != '0) ordErr++;
          for (int g = 0; g < NG; g++) begin
            if (rise[g]) begin
              if (!expTgt[g]) ordErr++;
              for (int h = 0; h < NG; h++)
                if (ON_R[h] < ON_R[g] && expTgt[h] && !prevEn[h]) ordErr++;
            end
            if (fall[g]) begin
              if (expTgt[g]) ordErr++;
              for (int h = 0; h < NG; h++)
                if (OFF_R[h] < OFF_R[g] && !expTgt[h] && prevEn[h]) ordErr++;
            end
          end
        end
        if (fall[0]) begin tieSeen = 1'b1; tieHit = fall[3]; end
      end
      prevEn = enOut;
      pgReg  = enOut & ~pgBlock;
    end
  end

  function automatic logic expAllGood(logic [NG-1:0] pg);
    return (pg == '1);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chkCnt++; errCnt++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    summary();
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    pgManual = 1'b0; pgRand = '0; pgBlock = '0; monOn = 1'b1; expTgt = '0;
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R1 reset state
    check(enOut == '0, "R1 enables", enOut, 0);
    check(ovFlag == '0 && uvFlag == '0 && !toFault, "R1 flags", {ovFlag, uvFlag, toFault}, 0);
    check(rstPulse == 1'b1, "R1 pulse idle", rstPulse, 1);

    // R2 power-up latency and order
    ctrlIn = 1'b1; expTgt = '1;
    cyc(2 + G0_DLY);
    check(enOut == '0, "R2 before first rank", enOut, 0);
    cyc(1);
    check(enOut == 6'h01, "R2 first rank edge", enOut, 6'h01);
    cyc(150);
    check(enOut == 6'h3F, "R2 all on", enOut, 6'h3F);
    check(ordErr == 0, "R2 order", ordErr, 0);

    // R6 fault latch while on
    ovIn = 6'h04; uvIn = 6'h20;
    cyc(1);
    ovIn = '0; uvIn = '0;
    cyc(1);
    check(ovFlag == 6'h04 && uvFlag == 6'h20, "R6 latched", {ovFlag, uvFlag}, {6'h04, 6'h20});

    // R3 power-down order, R10 pulse
    ctrlIn = 1'b0; expTgt = '0; tieSeen = 1'b0;
    cyc(1);
    check(rstPulse == 1'b0, "R10 pulse start", rstPulse, 0);
    cyc(PLEN - 1);
    check(rstPulse == 1'b0, "R10 pulse last cycle", rstPulse, 0);
    cyc(1);
    check(rstPulse == 1'b1, "R10 pulse end", rstPulse, 1);
    cyc(100);
    check(enOut == '0, "R3 all off", enOut, 0);
    check(tieSeen && tieHit, "R3 tied ranks together", {tieSeen, tieHit}, 2'b11);
    check(ordErr == 0, "R3 order", ordErr, 0);
    check(ovFlag == 6'h04 && uvFlag == 6'h20, "R6 kept after release", {ovFlag, uvFlag}, {6'h04, 6'h20});

    // R6 clear on control rise, then R9 abandon mid-sequence
    ctrlIn = 1'b1; expTgt = '1;
    cyc(1);
    check(ovFlag == '0 && uvFlag == '0, "R6 cleared on rise", {ovFlag, uvFlag}, 0);
    cyc(14);
    check(enOut != '0 && enOut != 6'h3F, "R9 mid sequence", enOut, 6'h3F);
    ctrlIn = 1'b0; expTgt = '0;
    cyc(120);
    check(enOut == '0 && ordErr == 0, "R9 settled off", enOut, 0);
    ctrlIn = 1'b1; expTgt = '1;
    cyc(8);
    ctrlIn = 1'b0; expTgt = '0;
    cyc(120);
    check(enOut == '0 && ordErr == 0, "R9 early reversal", enOut, 0);

    // R8 power-good timeout
    monOn = 1'b0; pgBlock = 6'h10;
    ctrlIn = 1'b1;
    cyc(200);
    check(toFault == 1'b1, "R8 fault set", toFault, 1);
    check(enOut == '0, "R8 shut down", enOut, 0);
    pgBlock = '0;
    ctrlIn = 1'b0;
    cyc(60);
    prevEn = enOut; monOn = 1'b1; expTgt = '1;
    ctrlIn = 1'b1;
    cyc(1);
    check(toFault == 1'b0, "R8 fault cleared", toFault, 0);
    cyc(150);
    check(enOut == 6'h3F && ordErr == 0, "R8 recovery", enOut, 6'h3F);
    ctrlIn = 1'b0; expTgt = '0;
    cyc(120);

    // R4 automatic mode
    modeSel = 2'b00; expTgt = '1;
    cyc(150);
    check(enOut == 6'h3F && ordErr == 0, "R4 auto up", enOut, 6'h3F);
    ctrlIn = 1'b1; cyc(20); ctrlIn = 1'b0; cyc(80);
    check(enOut == 6'h3F, "R4 control ignored", enOut, 6'h3F);

    // R7 pin-selected patterns, random plus a directed walk
    modeSel = 2'b10;
    for (int i = 0; i < 14; i++) begin
      logic [2:0] p;
      p = (i < 4) ? 3'(i + 2) : 3'($urandom % 8);
      pinSel = p; expTgt = PAT[p];
      cyc(150);
      check(enOut == PAT[p], "R7 pattern", enOut, PAT[p]);
    end
    check(ordErr == 0, "R7 only changed groups in order", ordErr, 0);

    // R5 all-good from random power-good vectors
    pgManual = 1'b1;
    for (int i = 0; i < 20; i++) begin
      pgRand = (i == 0) ? '1 : NG'($urandom);
      #1;
      check(allGood == expAllGood(pgRand), "R5 all good", allGood, expAllGood(pgRand));
      cyc(1);
    end
    pgManual = 1'b0;

    summary();
  end

endmodule